// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU

This block is a purely combinational arithmetic logic unit for a datapath. It takes two operand words and a 3-bit operation code. It returns a result word and three flags: a zero indicator, a signed overflow indicator and the carry leaving the top bit. It is built from identical one-bit slices. Each slice holds an AND gate, an OR gate, a full adder and a four-way result selector. The carry ripples through the slices from bit 0 upward.

Subtraction uses the same adder. Operation bit 2 inverts every bit of B and also supplies a carry of 1 into slice 0. The signed less-than operation subtracts the operands. It then takes the sign bit of the top slice's sum and feeds it back to slice 0 as that slice's "less" input. The "less" input of every other slice is tied low. An equality test is a subtraction followed by a look at the zero flag.

Top module: `bitslice_alu`

## Requirements
- R1: With op = 3'b000 the result is the bitwise AND of A and B, and with op = 3'b001 it is the bitwise OR.
- R2: With op = 3'b010 the result is A + B modulo 2^WIDTH.
- R3: With op = 3'b110 the result is A - B modulo 2^WIDTH, formed as A + ~B + 1.
- R4: The carry flag is always the carry out of the top slice of the internal adder. That adder sees ~B with a carry-in of 1 when op[2] is 1, and sees B with a carry-in of 0 when op[2] is 0. For a subtraction the flag is therefore 1 exactly when A >= B unsigned.
- R5: With op = 3'b111, result bit 0 equals the sign bit (bit WIDTH-1) of the wrapped difference A - B, and every other result bit is 0.
- R6: The zero flag is 1 exactly when every result bit is 0. With op = 3'b110 it is therefore 1 exactly when A equals B.
- R7: For add and subtract, the overflow flag is the XOR of the carry into the top slice and the carry out of the top slice. This equals the signed two's-complement overflow of the operation.
- R8: The overflow flag is 0 for the AND, OR and less-than operations.
- R9: The unused codes 3'b011, 3'b100 and 3'b101 give an all-zero result, and the overflow flag is 0 for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| op | input | 3 | Operation code; bit 2 negates B, bits 1:0 select the slice output |
| result | output | WIDTH | Result word |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow for add and subtract |
| carry_out | output | 1 | Carry leaving the top slice |

## Verification
The bench builds the block with its default WIDTH of 32. At that width the operand values 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF sit at the real signed and unsigned boundaries. The bench drives these values to reach overflow in both directions, a borrow-free subtraction of equal operands, and a less-than result whose sign bit wraps. Random operand pairs then exercise every opcode. The unused codes also run with operands whose sum is negative, to confirm that no slice output leaks through.

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf,
  output logic             carry_out
);
  localparam int MSB = WIDTH - 1;

  logic             negate_b;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] slice_out;
  logic [WIDTH-1:0] sum_bits;
  logic             set_sign;
  logic             code_valid;
  logic             arith_op;

  assign negate_b = op[2];
  assign chain[0] = negate_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic bi;
    logic less_in;
    assign bi          = opb[i] ^ negate_b;
    assign sum_bits[i] = opa[i] ^ bi ^ chain[i];
    assign chain[i+1]  = (opa[i] & bi) | (opa[i] & chain[i]) | (bi & chain[i]);
    if (i == 0) begin : g_lsb
      assign less_in = set_sign;
    end else begin : g_rest
      assign less_in = 1'b0;
    end
    always_comb begin
      case (op[1:0])
        2'b00:   slice_out[i] = opa[i] & bi;
        2'b01:   slice_out[i] = opa[i] | bi;
        2'b10:   slice_out[i] = sum_bits[i];
        default: slice_out[i] = less_in;
      endcase
    end
  end

  assign set_sign   = sum_bits[MSB];
  assign code_valid = (op == 3'b000) || (op == 3'b001) || (op == 3'b010) ||
                      (op == 3'b110) || (op == 3'b111);
  assign arith_op   = (op == 3'b010) || (op == 3'b110);

  assign result    = code_valid ? slice_out : '0;
  assign zero      = ~|result;
  assign carry_out = chain[WIDTH];
  assign ovf       = arith_op & (chain[MSB] ^ chain[WIDTH]);
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             ovf,
  input logic             carry_out
);
  always_comb begin
    if (op == 3'b110) begin
      AST_SUB_EQ_ZERO: assert (zero == (opa == opb));                        // R6
      AST_SUB_CARRY: assert (carry_out == (opa >= opb));                     // R4
    end
    if (op == 3'b111)
      AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0);                 // R5
    if (op == 3'b000 || op == 3'b001 || op == 3'b111)
      AST_NO_OVERFLOW: assert (!ovf);                                        // R8
    if (op == 3'b011 || op == 3'b100 || op == 3'b101)
      AST_UNUSED_QUIET: assert (result == '0 && !ovf && zero);               // R9
    if (op == 3'b010)
      AST_ADD_OVF: assert (ovf == ((opa[WIDTH-1] == opb[WIDTH-1]) &&
                                   (result[WIDTH-1] != opa[WIDTH-1])));      // R7
  end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .opa(opa), .opb(opb), .op(op), .result(result),
  .zero(zero), .ovf(ovf), .carry_out(carry_out)
);

// File: tb/bitslice_alu_tb_top.sv
module bitslice_alu_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] result;
  logic         zero, ovf, cout;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  bitslice_alu #(.WIDTH(W)) dut_i (
    .opa(a), .opb(b), .op(op), .result(result),
    .zero(zero), .ovf(ovf), .carry_out(cout)
  );

  task automatic run(input logic [W-1:0] va, input logic [W-1:0] vb,
                     input logic [2:0] vop, input string tag);
    logic [W-1:0] bx, sum, er;
    logic [W:0]   s;
    logic         ez, eo, ec;
    @(posedge clk);
    a = va; b = vb; op = vop;
    @(negedge clk);
    bx = vop[2] ? ~vb : vb;
    s = {1'b0, va} + {1'b0, bx} + {{W{1'b0}}, vop[2]};
    sum = s[W-1:0];
    ec = s[W];
    case (vop)
      3'b000:  er = va & vb;
      3'b001:  er = va | vb;
      3'b010, 3'b110: er = sum;
      3'b111:  er = {{(W-1){1'b0}}, sum[W-1]};
      default: er = '0;
    endcase
    ez = (er == '0);
    eo = (vop == 3'b010 || vop == 3'b110) &&
         (va[W-1] == bx[W-1]) && (sum[W-1] != va[W-1]);
    n_chk++;
    if (result !== er || zero !== ez || ovf !== eo || cout !== ec) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h: got res=%h z=%b v=%b c=%b, expected res=%h z=%b v=%b c=%b",
               tag, vop, va, vb, result, zero, ovf, cout, er, ez, eo, ec);
    end
  endtask

  task automatic t_idle();
    run('0, '0, 3'b000, "R6 idle zero");
  endtask

  task automatic t_logic();
    run(32'hF0F0_A5A5, 32'hFF00_0FF0, 3'b000, "R1 and");
    run(32'hF0F0_A5A5, 32'hFF00_0FF0, 3'b001, "R1 or");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, "R4 R8 and carry");
  endtask

  task automatic t_add();
    run(32'd1234, 32'd4321, 3'b010, "R2 add");
    run(32'hFFFF_FFFF, 32'd1, 3'b010, "R2 R4 R6 add wrap");
    run(32'h7FFF_FFFF, 32'd1, 3'b010, "R7 add pos ovf");
    run(32'h8000_0000, 32'h8000_0000, 3'b010, "R7 add neg ovf");
  endtask

  task automatic t_sub();
    run(32'd50, 32'd20, 3'b110, "R3 sub");
    run(32'd20, 32'd50, 3'b110, "R3 R4 sub borrow");
    run(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110, "R6 sub equal");
    run(32'h8000_0000, 32'd1, 3'b110, "R7 sub ovf");
    run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, "R7 sub ovf2");
  endtask

  task automatic t_slt();
    run(32'hFFFF_FFFF, 32'd1, 3'b111, "R5 slt neg");
    run(32'd5, 32'd3, 3'b111, "R5 slt false");
    run(32'd3, 32'd5, 3'b111, "R5 R8 slt true");
    run(32'h8000_0000, 32'd1, 3'b111, "R5 slt wrapped sign");
  endtask

  task automatic t_unused();
    run(32'h8000_0000, 32'h7FFF_FFFF, 3'b011, "R9 code3");
    run(32'h8000_0000, 32'h8000_0000, 3'b100, "R9 code4");
    run(32'hFFFF_FFFF, 32'h1234_5678, 3'b101, "R9 code5");
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [2:0] rop;
      rop = 3'($urandom());
      run(W'($urandom()), W'($urandom()), rop, "R1 R2 R3 R5 R9 random");
    end
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_unused();
    t_random();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule